// File: doc/BRIEF.md
# Rotated-ECC Sub-Rank Request Mapper

This block sits in front of a rank of nine independently controlled x8 DRAM chips, eight carrying data and one carrying a SEC-DED check byte per data chip. The chip that holds the check bytes is not fixed. It rotates from line to line as the residue modulo 9 of the line's column address, which spreads check-byte traffic evenly over all nine chips. Each accepted request is turned into per-chip command enables. Coarse requests address the whole rank at once. Fine-grained requests address only the chips they need, at most two disjoint chips per cycle.

A fine-grained read that already carries the line's check bytes, kept in the invalid sectors of a cache line, skips the check-byte chip. For writes, the block builds the outgoing check-byte lane: freshly encoded bytes for the words being written, and the cached bytes for every other word. Coarse writebacks with a partial word mask mask off the chips of the words not written.

Top module: `subrank_mapper`

## Requirements
- R1: After reset no command is presented (cmd_valid low, cmd_en zero) and req_ready is high.
- R2: The check-byte chip index reported on cmd_ecc_chip equals req_col modulo 9, for every column value.
- R3: Data word w (0..7) is placed on chip w when w is below the check-byte chip index, and on chip w+1 otherwise.
- R4: A coarse read (req_kind 0) produces exactly one command cycle with all nine chips enabled, cmd_coarse high, cmd_write low and cmd_wmask zero.
- R5: A coarse write (req_kind 1) produces one command cycle with all nine chips enabled and cmd_write high. cmd_wmask has a bit set on the chip of every word whose req_words bit is 0, and it is never set on the check-byte chip.
- R6: A fine read (req_kind 2) enables the chips of the selected words. It also enables the check-byte chip unless req_ecc_held is 1.
- R7: A fine write (req_kind 3) enables the chips of the selected words and always the check-byte chip, with cmd_write high.
- R8: Fine commands enable one or two chips per cycle. The needed chips are issued in ascending chip order, two per cycle, in consecutive cycles with no gaps.
- R9: On every write command, byte i of cmd_ecc_bytes (bits 8i+7..8i) is byte i of req_ecc_fresh when word i is selected, and byte i of req_ecc_cached otherwise.
- R10: req_ready is low while any command of an accepted request is still to be issued. The first command appears in the cycle after acceptance.
- R11: A fine read with no word selected and req_ecc_held set is accepted but produces no command, and req_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 coarse read, 1 coarse write, 2 fine read, 3 fine write |
| req_words | input | 8 | Selected (or dirty) words of the line |
| req_col | input | COL_W | Column address bits just above the line offset |
| req_ecc_held | input | 1 | Fine read carries the cached check bytes |
| req_ecc_cached | input | 64 | Check bytes held in the cache, byte i for word i |
| req_ecc_fresh | input | 64 | Newly encoded check bytes, byte i for word i |
| cmd_valid | output | 1 | A command slot is presented this cycle |
| cmd_write | output | 1 | The command is a write |
| cmd_coarse | output | 1 | The command addresses the whole rank |
| cmd_en | output | 9 | Per-chip command enables |
| cmd_wmask | output | 9 | Per-chip write masks (1 = do not write) |
| cmd_ecc_chip | output | 4 | Check-byte chip index of the current line |
| cmd_ecc_bytes | output | 64 | Merged check-byte lane for writes |

## Verification
The assertions assume that req_kind holds only the four defined codes and that a request is held stable only in the cycle it is accepted. The bench meets this by raising req_valid for exactly one edge, and only while req_ready is high. The properties also assume that req_col is a plain binary value of COL_W bits. The bench drives columns across the whole range, including values that are multiples of 9 and the all-ones value. It drives word masks that are empty, single, sparse and full, so every rotation position and both slot-pairing parities occur.

// File: rtl/subrank_pkg.sv
package subrank_pkg;
  localparam int WORDS  = 8;
  localparam int CHIPS  = WORDS + 1;
  localparam int BYTE_W = 8;
  localparam int CIDX_W = $clog2(CHIPS);

  localparam logic [1:0] K_CRD = 2'd0;
  localparam logic [1:0] K_CWR = 2'd1;
  localparam logic [1:0] K_FRD = 2'd2;
  localparam logic [1:0] K_FWR = 2'd3;

  // keep at most the two lowest set bits of a chip vector
  function automatic logic [CHIPS-1:0] low_two(input logic [CHIPS-1:0] v);
    logic [CHIPS-1:0] r;
    int n;
    r = '0;
    n = 0;
    for (int i = 0; i < CHIPS; i++) begin
      if (v[i] && n < 2) begin
        r[i] = 1'b1;
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sr_residue9.sv
module sr_residue9 #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0]                col,
  output logic [subrank_pkg::CIDX_W-1:0]  res
);
  localparam int NDIG = (COL_W + 2) / 3;
  localparam int PAD  = NDIG * 3;

  logic [PAD-1:0] ext;
  assign ext = PAD'(col);

  // 8 = -1 (mod 9): octal digits alternate in sign, then a bounded fold
  always_comb begin
    int s;
    s = 0;
    for (int k = 0; k < NDIG; k++) begin
      if ((k % 2) == 0) s = s + int'(ext[3*k +: 3]);
      else              s = s - int'(ext[3*k +: 3]);
    end
    s = s + 9 * NDIG;
    for (int j = 0; j < 2 * NDIG + 1; j++) begin
      if (s >= 9) s = s - 9;
    end
    res = s[subrank_pkg::CIDX_W-1:0];
  end
endmodule

// File: rtl/sr_lane_map.sv
module sr_lane_map
  import subrank_pkg::*;
(
  input  logic [WORDS-1:0]  words,
  input  logic [CIDX_W-1:0] ecc_chip,
  input  logic              add_ecc,
  output logic [CHIPS-1:0]  chips
);
  for (genvar c = 0; c < CHIPS; c++) begin : g_chip
    if (c == 0) begin : g_first
      assign chips[c] = (ecc_chip == CIDX_W'(c)) ? add_ecc : words[c];
    end else if (c == CHIPS - 1) begin : g_last
      assign chips[c] = (ecc_chip == CIDX_W'(c)) ? add_ecc : words[c-1];
    end else begin : g_mid
      assign chips[c] = (ecc_chip == CIDX_W'(c)) ? add_ecc :
                        (ecc_chip > CIDX_W'(c)) ? words[c] : words[c-1];
    end
  end
endmodule

// File: rtl/sr_ecc_merge.sv
module sr_ecc_merge
  import subrank_pkg::*;
(
  input  logic [WORDS-1:0]        sel,
  input  logic [WORDS*BYTE_W-1:0] fresh,
  input  logic [WORDS*BYTE_W-1:0] cached,
  output logic [WORDS*BYTE_W-1:0] merged
);
  for (genvar i = 0; i < WORDS; i++) begin : g_byte
    assign merged[i*BYTE_W +: BYTE_W] = sel[i] ? fresh[i*BYTE_W +: BYTE_W]
                                               : cached[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/subrank_mapper.sv
module subrank_mapper
  import subrank_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [WORDS-1:0]         req_words,
  input  logic [COL_W-1:0]         req_col,
  input  logic                     req_ecc_held,
  input  logic [WORDS*BYTE_W-1:0]  req_ecc_cached,
  input  logic [WORDS*BYTE_W-1:0]  req_ecc_fresh,
  output logic                     cmd_valid,
  output logic                     cmd_write,
  output logic                     cmd_coarse,
  output logic [CHIPS-1:0]         cmd_en,
  output logic [CHIPS-1:0]         cmd_wmask,
  output logic [CIDX_W-1:0]        cmd_ecc_chip,
  output logic [WORDS*BYTE_W-1:0]  cmd_ecc_bytes
);
  localparam logic [CHIPS-1:0] ALL_CHIPS = '1;

  // request-side decode
  logic [CIDX_W-1:0]       res_w;
  logic [CHIPS-1:0]        need_w;
  logic [CHIPS-1:0]        gap_w;
  logic [WORDS*BYTE_W-1:0] merged_w;
  logic                    is_coarse_w;
  logic                    is_write_w;
  logic                    want_ecc_w;

  assign is_coarse_w = (req_kind == K_CRD) || (req_kind == K_CWR);
  assign is_write_w  = (req_kind == K_CWR) || (req_kind == K_FWR);
  assign want_ecc_w  = (req_kind == K_FWR) || !req_ecc_held;

  sr_residue9 #(.COL_W(COL_W)) u_res (.col(req_col), .res(res_w));

  sr_lane_map u_need (.words(req_words), .ecc_chip(res_w),
                      .add_ecc(want_ecc_w), .chips(need_w));

  sr_lane_map u_gap (.words(~req_words), .ecc_chip(res_w),
                     .add_ecc(1'b0), .chips(gap_w));

  sr_ecc_merge u_merge (.sel(req_words), .fresh(req_ecc_fresh),
                        .cached(req_ecc_cached), .merged(merged_w));

  // issue state
  logic [CHIPS-1:0]        pend_q;
  logic                    coarse_q;
  logic                    write_q;
  logic [CHIPS-1:0]        wmask_q;
  logic [CIDX_W-1:0]       chip_q;
  logic [WORDS*BYTE_W-1:0] ecc_q;
  logic                    accept;
  logic                    slot_fire;

  assign req_ready = (pend_q == '0);
  assign accept    = req_valid && req_ready;
  assign cmd_valid = (pend_q != '0);
  assign slot_fire = cmd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      coarse_q <= 1'b0;
      write_q  <= 1'b0;
      wmask_q  <= '0;
      chip_q   <= '0;
      ecc_q    <= '0;
    end else if (accept) begin
      pend_q   <= is_coarse_w ? ALL_CHIPS : need_w;
      coarse_q <= is_coarse_w;
      write_q  <= is_write_w;
      wmask_q  <= (req_kind == K_CWR) ? gap_w : '0;
      chip_q   <= res_w;
      ecc_q    <= merged_w;
    end else if (slot_fire) begin
      pend_q   <= pend_q & ~cmd_en;
    end
  end

  assign cmd_en        = coarse_q ? pend_q : low_two(pend_q);
  assign cmd_write     = cmd_valid && write_q;
  assign cmd_coarse    = cmd_valid && coarse_q;
  assign cmd_wmask     = cmd_valid ? wmask_q : '0;
  assign cmd_ecc_chip  = chip_q;
  assign cmd_ecc_bytes = cmd_write ? ecc_q : '0;

  // R2: residue stays a legal chip index
  p_residue_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_w < CIDX_W'(CHIPS));

  // R4: coarse commands address the whole rank
  p_coarse_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_coarse |-> (cmd_en == ALL_CHIPS));

  // R5: the check-byte chip is never masked
  p_ecc_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cmd_wmask[cmd_ecc_chip]);

  // R8: fine slots carry one or two chips
  p_pair_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_coarse) |-> ($countones(cmd_en) == 1 || $countones(cmd_en) == 2));

  // R8: later slots of one request use strictly higher chips
  p_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_coarse) |=>
      (!cmd_valid || (((cmd_en & $past(cmd_en)) == '0) && (cmd_en > $past(cmd_en)))));

  // R10: a coarse request shows its command the next cycle
  p_accept_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_coarse_w) |=> (cmd_valid && cmd_coarse));
endmodule

// File: tb/subrank_mapper_test.sv
module subrank_mapper_test;
  import subrank_pkg::*;
  localparam int COL_W = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [1:0] req_kind = 0;
  logic [7:0] req_words = 0;
  logic [COL_W-1:0] req_col = 0;
  logic req_ecc_held = 0;
  logic [63:0] req_ecc_cached = 0;
  logic [63:0] req_ecc_fresh = 0;
  logic cmd_valid, cmd_write, cmd_coarse;
  logic [8:0] cmd_en, cmd_wmask;
  logic [3:0] cmd_ecc_chip;
  logic [63:0] cmd_ecc_bytes;

  int vectors = 0;
  int misses = 0;

  always #2 clk = ~clk;

  subrank_mapper #(.COL_W(COL_W)) uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int chip_of(input int w, input int e);
    return (w < e) ? w : w + 1;
  endfunction

  // generic request: drive, accept, then walk the slots
  task automatic run_req(input logic [1:0] kind, input logic [7:0] words,
                         input logic [COL_W-1:0] col, input logic held,
                         input logic [63:0] cached, input logic [63:0] fresh);
    int e;
    logic [8:0] need;
    logic [8:0] gap;
    logic [63:0] exp_ecc;
    int list[9];
    int n;
    int slots;
    e = int'(col) % 9;
    need = '0;
    gap = '0;
    for (int w = 0; w < 8; w++) begin
      if (words[w]) need[chip_of(w, e)] = 1'b1;
      else gap[chip_of(w, e)] = 1'b1;
      exp_ecc[w*8 +: 8] = words[w] ? fresh[w*8 +: 8] : cached[w*8 +: 8];
    end
    if (kind == K_FWR || (kind == K_FRD && !held)) need[e] = 1'b1;
    n = 0;
    for (int c = 0; c < 9; c++) if (need[c]) begin list[n] = c; n++; end

    @(negedge clk);
    check("R10 ready before request", 64'(req_ready), 64'd1);
    req_kind = kind; req_words = words; req_col = col; req_ecc_held = held;
    req_ecc_cached = cached; req_ecc_fresh = fresh; req_valid = 1;
    @(posedge clk);
    #1 req_valid = 0;

    if (kind == K_CRD || kind == K_CWR) begin
      @(negedge clk);
      check("R4 coarse valid", 64'(cmd_valid), 64'd1);
      check("R4 coarse enables", 64'(cmd_en), 64'h1FF);
      check("R4 coarse flag", 64'(cmd_coarse), 64'd1);
      check("R2 ecc chip", 64'(cmd_ecc_chip), 64'(e));
      check("R10 ready low busy", 64'(req_ready), 64'd0);
      if (kind == K_CRD) begin
        check("R4 read no write", 64'(cmd_write), 64'd0);
        check("R4 read no mask", 64'(cmd_wmask), 64'd0);
      end else begin
        check("R5 write flag", 64'(cmd_write), 64'd1);
        check("R5 write mask", 64'(cmd_wmask), 64'(gap));
        check("R9 merged ecc coarse", cmd_ecc_bytes, exp_ecc);
      end
      @(posedge clk);
    end else begin
      slots = (n + 1) / 2;
      for (int s = 0; s < slots; s++) begin
        logic [8:0] exp_en;
        exp_en = '0;
        exp_en[list[2*s]] = 1'b1;
        if (2*s + 1 < n) exp_en[list[2*s+1]] = 1'b1;
        @(negedge clk);
        check("R8 fine slot valid", 64'(cmd_valid), 64'd1);
        check(kind == K_FWR ? "R7 fine write slot" : "R6 fine read slot",
              64'(cmd_en), 64'(exp_en));
        check("R2 ecc chip fine", 64'(cmd_ecc_chip), 64'(e));
        check("R10 ready low busy", 64'(req_ready), 64'd0);
        check("R7 write flag", 64'(cmd_write), 64'(kind == K_FWR));
        if (kind == K_FWR) check("R9 merged ecc fine", cmd_ecc_bytes, exp_ecc);
        @(posedge clk);
      end
    end
    @(negedge clk);
    check("R8 no extra slot", 64'(cmd_valid), 64'd0);
    check("R10 ready after", 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 no command", 64'(cmd_valid), 64'd0);
    check("R1 enables zero", 64'(cmd_en), 64'd0);
    check("R1 ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_residue();
    int cols[8] = '{0, 8, 9, 17, 100, 511, 1000, 1023};
    foreach (cols[i]) run_req(K_CRD, 8'hFF, COL_W'(cols[i]), 1'b0, 64'h0, 64'h0);
  endtask

  task automatic t_word_map();
    // single word with held ECC: one chip, shifted past the ECC chip (R3)
    for (int e = 0; e < 9; e++)
      for (int w = 0; w < 8; w += 3)
        run_req(K_FRD, 8'(1 << w), COL_W'(e + 9 * 7), 1'b1, 64'h0, 64'h0);
  endtask

  task automatic t_empty_held();
    run_req(K_FRD, 8'h00, COL_W'(5), 1'b1, 64'h0, 64'h0);
    @(negedge clk);
    check("R11 still idle", 64'(cmd_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_residue();
    t_word_map();
    run_req(K_FRD, 8'b1010_0101, COL_W'(22), 1'b0, 64'h0, 64'h0);
    run_req(K_FRD, 8'hFF, COL_W'(1023), 1'b1, 64'h0, 64'h0);
    run_req(K_FRD, 8'hFF, COL_W'(4), 1'b0, 64'h0, 64'h0);
    run_req(K_FWR, 8'b0000_1000, COL_W'(13), 1'b1,
            64'h1122_3344_5566_7788, 64'hA1B2_C3D4_E5F6_0718);
    run_req(K_FWR, 8'h00, COL_W'(40), 1'b0, 64'hDEAD_BEEF_0BAD_F00D, 64'h0);
    run_req(K_FWR, 8'b1100_0011, COL_W'(8), 1'b0,
            64'h0F0E_0D0C_0B0A_0908, 64'hF0E0_D0C0_B0A0_9080);
    run_req(K_CWR, 8'b0110_0001, COL_W'(3), 1'b0,
            64'h0102_0304_0506_0708, 64'h8877_6655_4433_2211);
    run_req(K_CWR, 8'hFF, COL_W'(26), 1'b0, 64'h0, 64'hCAFE_F00D_1234_5678);
    run_req(K_CWR, 8'h00, COL_W'(0), 1'b0, 64'h55AA_55AA_55AA_55AA, 64'h0);
    t_empty_held();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #400000;
    misses++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule